// File: doc/BRIEF.md
# Packet Filter Bytecode Processor

This block runs a stored packet-filter program over one packet that already sits in a byte-addressed packet memory. It decides whether the packet is kept. The program is written into an internal instruction store through a simple write port while the engine is idle. Each `start` pulse then runs the program once from address 0. The processor works on a 32-bit accumulator A, a 32-bit index register X and a small word-addressed scratch store. It reads packet bytes through a four-byte-wide read port. It ends every run with a one-cycle `done` strobe, together with exactly one of `accept` or `reject`.

The engine steps each instruction through three stages in turn: fetch, execute and writeback, so one instruction takes three cycles. The execute stage drives the packet read address and evaluates the ALU result, the branch test and the bounds check. The writeback stage commits register and scratch writes, picks the next program counter, or closes the run.

Instruction word: bits 63:48 opcode, 47:40 taken offset, 39:32 not-taken offset, 31:0 constant k. The opcode low byte holds a class in bits 2:0 (0 load A, 1 load X, 2 store A, 3 store X, 4 ALU, 5 jump, 6 return, 7 register move). It holds a size in bits 4:3 (0 word, 1 half, 2 byte), an addressing mode in bits 7:5 (0 constant, 1 absolute, 2 indexed, 3 scratch, 4 packet length, 5 header length), a source select in bit 3 (0 uses k, 1 uses X) and an ALU or jump op in bits 7:4. Opcode bits 15:8 must be zero.

Top module: `pf_engine`

## Requirements
- R1: After reset, `busy`, `done`, `accept` and `reject` are low, and an idle engine stays idle until `start`.
- R2: A run of N straight-line instructions raises `done` exactly 3N cycles after the edge that samples `start`. `done` lasts one cycle.
- R3: A return op (0x06 returns k, 0x16 returns A) ends the run. A nonzero value gives `accept` and a zero value gives `reject`. Exactly one of the two is high, and only together with `done`. A and X are zero when a run starts.
- R4: Absolute loads into A (0x20 word, 0x28 half, 0x30 byte) read the packet at byte offset k, most significant byte first. Half and byte values are zero-extended.
- R5: Indexed loads (0x40, 0x48, 0x50) read at X + k.
- R6: The header-length load (0xB1) sets X to four times the low nibble of the packet byte at k.
- R7: A packet load whose last byte lies at or beyond `pktLen` ends the run with `reject` at once.
- R8: ALU ops (opcode 0x04 | op<<4 | src) cover add 0, sub 1, or 4, and 5, left shift 6, right shift 7, negate 8 and xor 10. The operand is k or X, and a shift uses the low five bits of the operand.
- R9: Compare jumps (0x15 equal, 0x25 greater, 0x35 greater-or-equal, 0x45 bit test with nonzero A&operand; +0x08 compares with X) continue at pc+1+taken offset or pc+1+not-taken offset. The always-jump 0x05 continues at pc+1+k.
- R10: Store ops (0x02 from A, 0x03 from X) write scratch word k. Loads 0x60 and 0x61 read scratch word k into A or X. Loads 0x80 and 0x81 give the packet length.
- R11: Op 0x07 copies A into X, and op 0x87 copies X into A.
- R12: Multiply, divide, modulo and any other undefined opcode end the run with `reject`.
- R13: A `start` while busy is ignored. A newly written program takes effect on the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| imemWrEn | input | 1 | Instruction store write enable |
| imemWrAddr | input | IMEM_AW | Instruction store write address |
| imemWrData | input | 64 | Instruction word to store |
| start | input | 1 | Begin one run at program address 0 |
| pktLen | input | PKT_AW+1 | Packet length in bytes |
| pktRdAddr | output | PKT_AW | Packet byte address, valid in the execute stage |
| pktRdData | input | 32 | Bytes addr..addr+3, first byte in bits 31:24, one cycle after the address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| accept | output | 1 | Packet kept, with `done` |
| reject | output | 1 | Packet dropped, with `done` |

## Verification
The properties assume that the instruction store is written only while `busy` is low. They also assume that `pktLen` stays fixed during a run and that the packet memory answers exactly one cycle after the address. The bench writes programs only between runs and changes the packet image and length only while idle. Its packet model is a registered read that returns four consecutive bytes, with zeros beyond the modelled image. Every value the design computes is made visible through an equality jump to an accept or reject return. A second run with a deliberately wrong constant shows that a match does not come from a stuck branch.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam logic [2:0] CLS_LD   = 3'd0;
  localparam logic [2:0] CLS_LDX  = 3'd1;
  localparam logic [2:0] CLS_ST   = 3'd2;
  localparam logic [2:0] CLS_STX  = 3'd3;
  localparam logic [2:0] CLS_ALU  = 3'd4;
  localparam logic [2:0] CLS_JMP  = 3'd5;
  localparam logic [2:0] CLS_RET  = 3'd6;
  localparam logic [2:0] CLS_MISC = 3'd7;

  typedef enum logic [2:0] {A_IMM, A_PKT, A_MEM, A_LEN, A_ALU, A_X} aSrc_e;
  typedef enum logic [2:0] {X_IMM, X_MEM, X_LEN, X_MSH, X_A} xSrc_e;

  typedef struct packed {
    logic       wrA;
    logic       wrX;
    logic       wrMem;
    logic       memFromX;
    aSrc_e      aSrc;
    xSrc_e      xSrc;
    logic [3:0] aluOp;
    logic       useX;
    logic [1:0] size;
    logic       indexed;
    logic       pktLoad;
    logic [2:0] jmpOp;
    logic       retA;
  } ctl_t;
endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               imemWrEn,
  input  logic [IMEM_AW-1:0] imemWrAddr,
  input  logic [63:0]        imemWrData,
  input  logic               start,
  input  logic               cond,
  input  logic               oob,
  input  logic               retNz,
  output ctl_t               ctl,
  output logic [31:0]        k,
  output logic               execEn,
  output logic               wbEn,
  output logic               clr,
  output logic               busy,
  output logic               done,
  output logic               accept,
  output logic               reject
);
  localparam int IMEM_DEPTH = 1 << IMEM_AW;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_WB} state_e;

  state_e             state;
  logic [IMEM_AW-1:0] pc;
  logic [63:0]        imem [IMEM_DEPTH];
  logic [63:0]        instrQ;
  logic [15:0]        op;
  logic [7:0]         jt, jf;
  logic               bad, isRet, isJmp, finish, verdict;
  logic [IMEM_AW-1:0] nextPc;

  assign op = instrQ[63:48];
  assign jt = instrQ[47:40];
  assign jf = instrQ[39:32];
  assign k  = instrQ[31:0];

  always_ff @(posedge clk) begin
    if (imemWrEn) imem[imemWrAddr] <= imemWrData;
  end

  always_comb begin
    ctl   = '0;
    bad   = (op[15:8] != 8'd0);
    isRet = 1'b0;
    isJmp = 1'b0;
    unique case (op[2:0])
      CLS_LD: begin
        ctl.wrA = 1'b1;
        ctl.size = op[4:3];
        case (op[7:5])
          3'd0: ctl.aSrc = A_IMM;
          3'd1: begin ctl.aSrc = A_PKT; ctl.pktLoad = 1'b1; bad = bad | (op[4:3] == 2'd3); end
          3'd2: begin ctl.aSrc = A_PKT; ctl.pktLoad = 1'b1; ctl.indexed = 1'b1; bad = bad | (op[4:3] == 2'd3); end
          3'd3: ctl.aSrc = A_MEM;
          3'd4: ctl.aSrc = A_LEN;
          default: bad = 1'b1;
        endcase
      end
      CLS_LDX: begin
        ctl.wrX = 1'b1;
        case (op[7:5])
          3'd0: ctl.xSrc = X_IMM;
          3'd3: ctl.xSrc = X_MEM;
          3'd4: ctl.xSrc = X_LEN;
          3'd5: begin ctl.xSrc = X_MSH; ctl.pktLoad = 1'b1; ctl.size = 2'd2; end
          default: bad = 1'b1;
        endcase
      end
      CLS_ST:  ctl.wrMem = 1'b1;
      CLS_STX: begin ctl.wrMem = 1'b1; ctl.memFromX = 1'b1; end
      CLS_ALU: begin
        ctl.wrA = 1'b1;
        ctl.aSrc = A_ALU;
        ctl.aluOp = op[7:4];
        ctl.useX = op[3];
        case (op[7:4])
          4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10: ;
          default: bad = 1'b1;
        endcase
      end
      CLS_JMP: begin
        isJmp = 1'b1;
        ctl.jmpOp = op[6:4];
        ctl.useX = op[3];
        bad = bad | (op[7:4] > 4'd4);
      end
      CLS_RET: begin
        isRet = 1'b1;
        ctl.retA = op[4];
        bad = bad | op[3] | (op[7:5] != 3'd0);
      end
      default: begin
        if (op[7:3] == 5'b00000) begin ctl.wrX = 1'b1; ctl.xSrc = X_A; end
        else if (op[7:3] == 5'b10000) begin ctl.wrA = 1'b1; ctl.aSrc = A_X; end
        else bad = 1'b1;
      end
    endcase
  end

  assign finish  = (state == S_WB) && (bad || oob || isRet);
  assign verdict = !bad && !oob && retNz;

  always_comb begin
    if (!isJmp)                 nextPc = pc + IMEM_AW'(1);
    else if (ctl.jmpOp == 3'd0) nextPc = pc + IMEM_AW'(1) + k[IMEM_AW-1:0];
    else if (cond)              nextPc = pc + IMEM_AW'(1) + jt[IMEM_AW-1:0];
    else                        nextPc = pc + IMEM_AW'(1) + jf[IMEM_AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      pc     <= '0;
      instrQ <= '0;
      done   <= 1'b0;
      accept <= 1'b0;
      reject <= 1'b0;
    end else begin
      done   <= 1'b0;
      accept <= 1'b0;
      reject <= 1'b0;
      case (state)
        S_IDLE: if (start) begin state <= S_FETCH; pc <= '0; end
        S_FETCH: begin instrQ <= imem[pc]; state <= S_EXEC; end
        S_EXEC: state <= S_WB;
        default: begin
          if (finish) begin
            done   <= 1'b1;
            accept <= verdict;
            reject <= !verdict;
            state  <= S_IDLE;
          end else begin
            pc    <= nextPc;
            state <= S_FETCH;
          end
        end
      endcase
    end
  end

  assign execEn = (state == S_EXEC);
  assign wbEn   = (state == S_WB) && !bad && !oob;
  assign clr    = (state == S_IDLE) && start;
  assign busy   = (state != S_IDLE);
endmodule

// File: rtl/pf_dp.sv
module pf_dp
  import pf_pkg::*;
#(
  parameter int PKT_AW    = 11,
  parameter int MEM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [31:0]       k,
  input  logic              execEn,
  input  logic              wbEn,
  input  logic              clr,
  input  logic [31:0]       pktRdData,
  input  logic [PKT_AW:0]   pktLen,
  output logic [PKT_AW-1:0] pktRdAddr,
  output logic              cond,
  output logic              oob,
  output logic              retNz
);
  localparam int MEM_AW = $clog2(MEM_WORDS);

  logic [31:0] regA, regX, aluQ, aluC, opnd, pktVal;
  logic [31:0] scratch [MEM_WORDS];
  logic        condQ, oobQ, condC, oobC;
  logic [32:0] addrFull;
  logic [33:0] endC;
  logic [2:0]  nBytes;
  logic [MEM_AW-1:0] memIdx;

  assign opnd     = ctl.useX ? regX : k;
  assign addrFull = {1'b0, (ctl.indexed ? regX : 32'd0)} + {1'b0, k};
  assign memIdx   = k[MEM_AW-1:0];

  always_comb begin
    case (ctl.size)
      2'd0:    nBytes = 3'd4;
      2'd1:    nBytes = 3'd2;
      default: nBytes = 3'd1;
    endcase
  end

  assign endC      = {1'b0, addrFull} + {31'd0, nBytes};
  assign oobC      = ctl.pktLoad && (endC > {{(33 - PKT_AW){1'b0}}, pktLen});
  assign pktRdAddr = addrFull[PKT_AW-1:0];

  always_comb begin
    case (ctl.aluOp)
      4'd0:    aluC = regA + opnd;
      4'd1:    aluC = regA - opnd;
      4'd4:    aluC = regA | opnd;
      4'd5:    aluC = regA & opnd;
      4'd6:    aluC = regA << opnd[4:0];
      4'd7:    aluC = regA >> opnd[4:0];
      4'd8:    aluC = 32'd0 - regA;
      4'd10:   aluC = regA ^ opnd;
      default: aluC = '0;
    endcase
    case (ctl.jmpOp)
      3'd0:    condC = 1'b1;
      3'd1:    condC = (regA == opnd);
      3'd2:    condC = (regA > opnd);
      3'd3:    condC = (regA >= opnd);
      3'd4:    condC = ((regA & opnd) != 32'd0);
      default: condC = 1'b0;
    endcase
    case (ctl.size)
      2'd0:    pktVal = pktRdData;
      2'd1:    pktVal = {16'd0, pktRdData[31:16]};
      default: pktVal = {24'd0, pktRdData[31:24]};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA  <= '0;
      regX  <= '0;
      aluQ  <= '0;
      condQ <= 1'b0;
      oobQ  <= 1'b0;
      for (int i = 0; i < MEM_WORDS; i++) scratch[i] <= '0;
    end else begin
      if (execEn) begin
        aluQ  <= aluC;
        condQ <= condC;
        oobQ  <= oobC;
      end
      if (clr) begin
        regA <= '0;
        regX <= '0;
      end else if (wbEn) begin
        if (ctl.wrA) begin
          case (ctl.aSrc)
            A_IMM:   regA <= k;
            A_PKT:   regA <= pktVal;
            A_MEM:   regA <= scratch[memIdx];
            A_LEN:   regA <= 32'(pktLen);
            A_ALU:   regA <= aluQ;
            default: regA <= regX;
          endcase
        end
        if (ctl.wrX) begin
          case (ctl.xSrc)
            X_IMM:   regX <= k;
            X_MEM:   regX <= scratch[memIdx];
            X_LEN:   regX <= 32'(pktLen);
            X_MSH:   regX <= {26'd0, pktRdData[27:24], 2'b00};
            default: regX <= regA;
          endcase
        end
        if (ctl.wrMem) scratch[memIdx] <= ctl.memFromX ? regX : regA;
      end
    end
  end

  assign cond  = condQ;
  assign oob   = oobQ;
  assign retNz = ((ctl.retA ? regA : k) != 32'd0);
endmodule

// File: rtl/pf_engine.sv
module pf_engine
  import pf_pkg::*;
#(
  parameter int IMEM_AW   = 6,
  parameter int PKT_AW    = 11,
  parameter int MEM_WORDS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               imemWrEn,
  input  logic [IMEM_AW-1:0] imemWrAddr,
  input  logic [63:0]        imemWrData,
  input  logic               start,
  input  logic [PKT_AW:0]    pktLen,
  output logic [PKT_AW-1:0]  pktRdAddr,
  input  logic [31:0]        pktRdData,
  output logic               busy,
  output logic               done,
  output logic               accept,
  output logic               reject
);
  ctl_t        ctl;
  logic [31:0] k;
  logic        execEn, wbEn, clr, cond, oob, retNz;

  pf_ctrl #(.IMEM_AW(IMEM_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .imemWrEn(imemWrEn), .imemWrAddr(imemWrAddr),
    .imemWrData(imemWrData), .start(start), .cond(cond), .oob(oob),
    .retNz(retNz), .ctl(ctl), .k(k), .execEn(execEn), .wbEn(wbEn),
    .clr(clr), .busy(busy), .done(done), .accept(accept), .reject(reject)
  );

  pf_dp #(.PKT_AW(PKT_AW), .MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .k(k), .execEn(execEn), .wbEn(wbEn),
    .clr(clr), .pktRdData(pktRdData), .pktLen(pktLen), .pktRdAddr(pktRdAddr),
    .cond(cond), .oob(oob), .retNz(retNz)
  );
endmodule

// File: rtl/pf_engine_chk.sv
module pf_engine_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic accept,
  input logic reject
);
  p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !busy);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (accept ^ reject));

  p_verdict_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept || reject) |-> done);

  p_start_launch_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind pf_engine pf_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .accept(accept), .reject(reject)
);

// File: tb/test_pf_engine.sv
module test_pf_engine;
  localparam int IMEM_AW = 6;
  localparam int PKT_AW  = 11;
  localparam int IMG     = 64;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               imemWrEn = 1'b0;
  logic [IMEM_AW-1:0] imemWrAddr = '0;
  logic [63:0]        imemWrData = '0;
  logic               start = 1'b0;
  logic [PKT_AW:0]    pktLen = 12'd40;
  logic [PKT_AW-1:0]  pktRdAddr;
  logic [31:0]        pktRdData = '0;
  logic               busy, done, accept, reject;

  logic [7:0] pmem [IMG];
  int nVec = 0;
  int nBad = 0;
  int lastCyc = 0;
  int tick = 0;

  pf_engine #(.IMEM_AW(IMEM_AW), .PKT_AW(PKT_AW)) i_pf_engine (
    .clk(clk), .rstN(rstN), .imemWrEn(imemWrEn), .imemWrAddr(imemWrAddr),
    .imemWrData(imemWrData), .start(start), .pktLen(pktLen),
    .pktRdAddr(pktRdAddr), .pktRdData(pktRdData), .busy(busy), .done(done),
    .accept(accept), .reject(reject)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] byteAt(input int a);
    return (a >= 0 && a < IMG) ? pmem[a] : 8'd0;
  endfunction

  always @(posedge clk) begin
    pktRdData <= {byteAt(int'(pktRdAddr)), byteAt(int'(pktRdAddr) + 1),
                  byteAt(int'(pktRdAddr) + 2), byteAt(int'(pktRdAddr) + 3)};
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ins(input int idx, input logic [15:0] op, input logic [7:0] jt,
                     input logic [7:0] jf, input logic [31:0] k);
    @(negedge clk);
    imemWrEn = 1'b1;
    imemWrAddr = IMEM_AW'(idx);
    imemWrData = {op, jt, jf, k};
  endtask

  // equality tail at idx: A==v -> accept, else reject
  task automatic tailEq(input int idx, input logic [31:0] v);
    ins(idx, 16'h0015, 8'd0, 8'd1, v);
    ins(idx + 1, 16'h0006, 8'd0, 8'd0, 32'd1);
    ins(idx + 2, 16'h0006, 8'd0, 8'd0, 32'd0);
  endtask

  task automatic runProg(input bit expAcc, input string req);
    int cyc;
    @(negedge clk);
    imemWrEn = 1'b0;
    start = 1'b1;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    lastCyc = cyc;
    if (!done) chk(1'b0, {req, " run hung"}, 0, 1);
    else chk(accept == expAcc && reject == !expAcc, req, {accept, reject}, {expAcc, !expAcc});
  endtask

  function automatic logic [31:0] aluRef(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      4: return a | b;
      5: return a & b;
      6: return a << b[4:0];
      7: return a >> b[4:0];
      8: return 32'd0 - a;
      default: return a ^ b;
    endcase
  endfunction

  initial begin
    while (tick < 150000) begin
      @(posedge clk);
      tick++;
    end
    chk(1'b0, "watchdog", tick, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [31:0] aV [6];
    logic [31:0] bV [6];
    int aluOps [8];
    for (int i = 0; i < IMG; i++) pmem[i] = 8'((i * 37 + 11) & 255);
    aV = '{32'd0, 32'd1, 32'h8000_0001, 32'hFFFF_FFFF, 32'd1234, 32'h0F0F_00F0};
    bV = '{32'd0, 32'd3, 32'd31, 32'd33, 32'hFFFF_FFFF, 32'd1234};
    aluOps = '{0, 1, 4, 5, 6, 7, 8, 10};

    repeat (3) @(negedge clk);
    chk(!busy && !done && !accept && !reject, "R1 reset state", {busy, done, accept, reject}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 idle without start", {busy, done}, 0);

    // R2/R3 return constant
    ins(0, 16'h0006, 8'd0, 8'd0, 32'd5);
    runProg(1'b1, "R3 ret nonzero");
    chk(lastCyc == 4, "R2 one-instruction latency", lastCyc, 4);
    @(negedge clk);
    chk(!done, "R2 done one cycle", done, 0);
    ins(0, 16'h0006, 8'd0, 8'd0, 32'd0);
    runProg(1'b0, "R3 ret zero");
    ins(0, 16'h0000, 8'd0, 8'd0, 32'd7);
    ins(1, 16'h0016, 8'd0, 8'd0, 32'd0);
    runProg(1'b1, "R3 ret A nonzero");
    chk(lastCyc == 7, "R2 two-instruction latency", lastCyc, 7);
    // R3 A cleared at start: previous run left A=7
    ins(0, 16'h0016, 8'd0, 8'd0, 32'd0);
    runProg(1'b0, "R3 A zero at start");

    // R4/R7 absolute load sweep
    pktLen = 12'd40;
    for (int off = 0; off < 44; off++) begin
      for (int s = 0; s < 3; s++) begin
        int n;
        logic [31:0] e;
        n = (s == 0) ? 4 : (s == 1) ? 2 : 1;
        e = (s == 0) ? {byteAt(off), byteAt(off + 1), byteAt(off + 2), byteAt(off + 3)}
          : (s == 1) ? {16'd0, byteAt(off), byteAt(off + 1)} : {24'd0, byteAt(off)};
        ins(0, 16'(8'h20 | (s << 3)), 8'd0, 8'd0, 32'(off));
        tailEq(1, e);
        runProg(off + n <= 40, (off + n <= 40) ? "R4 absolute load value" : "R7 load past length");
        if (off + n <= 40 && off % 7 == 0) begin
          tailEq(1, e ^ 32'd1);
          runProg(1'b0, "R4 load mismatch rejects");
        end
      end
    end

    // R5 indexed loads
    for (int j = 0; j < 8; j++) begin
      ins(0, 16'h0001, 8'd0, 8'd0, 32'(j));
      ins(1, 16'h0048, 8'd0, 8'd0, 32'd3);
      tailEq(2, {16'd0, byteAt(j + 3), byteAt(j + 4)});
      runProg(1'b1, "R5 indexed half load");
    end
    ins(0, 16'h0001, 8'd0, 8'd0, 32'd38);
    ins(1, 16'h0040, 8'd0, 8'd0, 32'd0);
    tailEq(2, 32'd0);
    runProg(1'b0, "R7 indexed load past length");

    // R6/R11 header-length load over every nibble
    for (int nib = 0; nib < 16; nib++) begin
      pmem[14] = 8'(8'hA0 | nib);
      ins(0, 16'h00B1, 8'd0, 8'd0, 32'd14);
      ins(1, 16'h0087, 8'd0, 8'd0, 32'd0);
      tailEq(2, 32'(4 * nib));
      runProg(1'b1, "R6 header length");
    end
    pmem[14] = 8'((14 * 37 + 11) & 255);

    // R8 ALU with constant and with X
    foreach (aluOps[o]) begin
      for (int ia = 0; ia < 6; ia++) begin
        for (int ib = 0; ib < 6; ib += 2) begin
          ins(0, 16'h0000, 8'd0, 8'd0, aV[ia]);
          ins(1, 16'(8'h04 | (aluOps[o] << 4)), 8'd0, 8'd0, bV[ib + (ia % 2)]);
          tailEq(2, aluRef(aluOps[o], aV[ia], bV[ib + (ia % 2)]));
          runProg(1'b1, "R8 ALU constant operand");
        end
      end
      ins(0, 16'h0000, 8'd0, 8'd0, 32'd3);
      ins(1, 16'h0007, 8'd0, 8'd0, 32'd0);
      ins(2, 16'h0000, 8'd0, 8'd0, 32'h1234_5678);
      ins(3, 16'(8'h0C | (aluOps[o] << 4)), 8'd0, 8'd0, 32'd99);
      tailEq(4, aluRef(aluOps[o], 32'h1234_5678, 32'd3));
      runProg(1'b1, "R8 ALU X operand");
    end

    // R9 compare jumps
    for (int ia = 0; ia < 6; ia++) begin
      for (int jo = 1; jo <= 4; jo++) begin
        logic [31:0] a;
        logic [31:0] b;
        bit t;
        a = aV[ia];
        b = bV[(ia + jo) % 6];
        t = (jo == 1) ? (a == b) : (jo == 2) ? (a > b) : (jo == 3) ? (a >= b) : ((a & b) != 0);
        ins(0, 16'h0000, 8'd0, 8'd0, a);
        ins(1, 16'(8'h05 | (jo << 4)), 8'd0, 8'd1, b);
        ins(2, 16'h0006, 8'd0, 8'd0, 32'd1);
        ins(3, 16'h0006, 8'd0, 8'd0, 32'd0);
        runProg(t, "R9 compare jump");
      end
    end
    ins(0, 16'h0000, 8'd0, 8'd0, 32'd9);
    ins(1, 16'h0015, 8'd2, 8'd0, 32'd9);
    ins(2, 16'h0006, 8'd0, 8'd0, 32'd0);
    ins(3, 16'h0006, 8'd0, 8'd0, 32'd0);
    ins(4, 16'h0006, 8'd0, 8'd0, 32'd1);
    runProg(1'b1, "R9 taken offset 2");
    ins(1, 16'h0015, 8'd0, 8'd2, 32'd8);
    runProg(1'b1, "R9 not-taken offset 2");
    ins(0, 16'h0001, 8'd0, 8'd0, 32'd9);
    ins(1, 16'h001D, 8'd2, 8'd0, 32'd0);
    runProg(1'b0, "R9 X compare false");
    ins(0, 16'h0005, 8'd0, 8'd0, 32'd3);
    ins(1, 16'h0006, 8'd0, 8'd0, 32'd0);
    runProg(1'b1, "R9 always jump");

    // R10 scratch and length
    ins(0, 16'h0000, 8'd0, 8'd0, 32'hCAFE_0001);
    ins(1, 16'h0002, 8'd0, 8'd0, 32'd3);
    ins(2, 16'h0000, 8'd0, 8'd0, 32'd0);
    ins(3, 16'h0061, 8'd0, 8'd0, 32'd3);
    ins(4, 16'h0087, 8'd0, 8'd0, 32'd0);
    tailEq(5, 32'hCAFE_0001);
    runProg(1'b1, "R10 store A load X");
    ins(0, 16'h0001, 8'd0, 8'd0, 32'h0BAD_F00D);
    ins(1, 16'h0003, 8'd0, 8'd0, 32'd9);
    ins(2, 16'h0060, 8'd0, 8'd0, 32'd9);
    tailEq(3, 32'h0BAD_F00D);
    runProg(1'b1, "R10 store X load A");
    pktLen = 12'd33;
    ins(0, 16'h0080, 8'd0, 8'd0, 32'd0);
    tailEq(1, 32'd33);
    runProg(1'b1, "R10 length into A");
    ins(0, 16'h0081, 8'd0, 8'd0, 32'd0);
    ins(1, 16'h0087, 8'd0, 8'd0, 32'd0);
    tailEq(2, 32'd33);
    runProg(1'b1, "R10 length into X");
    pktLen = 12'd40;

    // R11 register moves
    ins(0, 16'h0000, 8'd0, 8'd0, 32'd77);
    ins(1, 16'h0007, 8'd0, 8'd0, 32'd0);
    ins(2, 16'h0000, 8'd0, 8'd0, 32'd0);
    ins(3, 16'h0087, 8'd0, 8'd0, 32'd0);
    tailEq(4, 32'd77);
    runProg(1'b1, "R11 A to X to A");

    // R12 unsupported opcodes
    foreach (aluOps[o]) begin
      logic [15:0] badOp;
      badOp = (o == 0) ? 16'h0024 : (o == 1) ? 16'h0034 : (o == 2) ? 16'h0094 :
              (o == 3) ? 16'h00E0 : (o == 4) ? 16'h0038 : (o == 5) ? 16'h0065 :
              (o == 6) ? 16'h0107 : 16'h000E;
      ins(0, 16'h0000, 8'd0, 8'd0, 32'd1);
      ins(1, badOp, 8'd0, 8'd0, 32'd1);
      ins(2, 16'h0006, 8'd0, 8'd0, 32'd1);
      runProg(1'b0, "R12 undefined opcode");
    end

    // R13 start while busy is ignored; reload takes effect
    for (int i = 0; i < 4; i++) ins(i, 16'h0000, 8'd0, 8'd0, 32'(i));
    ins(4, 16'h0006, 8'd0, 8'd0, 32'd1);
    begin
      int cyc;
      int pulses;
      @(negedge clk);
      imemWrEn = 1'b0;
      start = 1'b1;
      cyc = 0;
      pulses = 0;
      while (cyc < 45) begin
        @(negedge clk);
        cyc++;
        start = (cyc == 5 || cyc == 9);
        if (done) begin
          pulses++;
          chk(cyc == 16 && accept, "R13 start while busy ignored", cyc, 16);
        end
      end
      start = 1'b0;
      chk(pulses == 1, "R13 single done", pulses, 1);
    end
    ins(4, 16'h0006, 8'd0, 8'd0, 32'd0);
    runProg(1'b0, "R13 reloaded program");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule